// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This controller connects a single-word read/write request port to a four-bank synchronous DRAM with an 8-bit data path. After reset it holds the memory idle for a power-up delay. It then closes every bank, runs two auto-refresh cycles and loads the mode register. From that point it accepts requests. Each accepted request becomes one ACTIVE command followed by one READ or WRITE that carries an auto-precharge flag, so only one row is ever open and every bank is closed again before the next command.

A refresh timer paces auto-refresh commands so that 4096 rows are covered every 64 ms. The interval is computed from a clock-frequency parameter. A due refresh is issued before any new request once the access in progress has finished. Read data comes back through a valid strobe whose position is fixed by the programmed CAS latency, either 2 or 3 cycles.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is held, CKE is low, DQM is high, the command is NOP, and both `init_done` and `req_ready` are low. After reset is released, the first non-NOP command appears on the bus exactly POWERUP_US*CLK_MHZ clock edges later.
- R2: The initialization sequence is, in order: PRECHARGE with A10=1 (all banks), AUTO REFRESH, AUTO REFRESH, then LOAD MODE. The LOAD MODE address is A[6:4]=CAS_LAT with every other bit zero, which selects burst length 1 and sequential order. `init_done` rises only after this sequence.
- R3: Commands are driven on {CS#,RAS#,CAS#,WE#} as follows: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. Every command is followed by at least one NOP.
- R4: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is initialized, idle and has no refresh pending. The request address is split as bank = `req_addr[22:21]`, row = `req_addr[20:9]` and column = `req_addr[8:0]`.
- R5: ACTIVE drives BA with the bank and A with the row. The following READ or WRITE drives the same BA, puts the column on A[8:0], sets A10=1 to request auto precharge, and holds A9 and A11 low.
- R6: The gap from ACTIVE to READ/WRITE is at least T_RCD. The gap between two ACTIVE commands is at least T_RC. The gap from AUTO REFRESH to the next command is at least T_RC. The gap from LOAD MODE to the next command is at least T_MRD.
- R7: After a READ, no ACTIVE or AUTO REFRESH is issued for CAS_LAT+T_RP cycles. After a WRITE, none is issued for T_WR+T_RP cycles.
- R8: `sd_dq_oe` is high only in the cycle that carries the WRITE command, and in that cycle `sd_dq_out` holds the write data.
- R9: `rd_valid` is a one-cycle pulse. It rises on the (CAS_LAT+1)-th rising edge after the edge that put READ on the bus, and `rd_data` then holds the value `sd_dq_in` had at that edge.
- R10: Once initialized, AUTO REFRESH is issued every CLK_MHZ*15625/1000 cycles while the port is idle. Under traffic, a due refresh is issued before the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | {bank, row, column} |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 8 | Read data |
| init_done | output | 1 | Initialization finished |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Multiplexed row/column address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | 8 | Data driven to memory |
| sd_dq_oe | output | 1 | Data bus output enable |
| sd_dq_in | input | 8 | Data returned by memory |

## Verification
A wrong state or wait count shows up on the command pins within one access. It appears as a READ issued too soon after ACTIVE, or as an ACTIVE or refresh that cuts into the precharge window, and the memory model flags it in the cycle it happens. A misplaced bank, row or column bit makes read-back data differ from the write pattern on the next sweep. A wrong latency pipeline moves `rd_valid` off the single cycle where the model drives real data, so a wrong byte is captured at once. A wrong refresh counter changes the spacing between refreshes during the idle window, so the error appears one refresh period later.

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl #(
  parameter int CLK_MHZ    = 125,
  parameter int CAS_LAT    = 2,
  parameter int T_RCD      = 2,
  parameter int T_RP       = 2,
  parameter int T_RC       = 7,
  parameter int T_WR       = 2,
  parameter int T_MRD      = 2,
  parameter int POWERUP_US = 100,
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 9,
  parameter int DATA_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          init_done,
  output logic                          sd_cke,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_a,
  output logic                          sd_dqm,
  output logic [DATA_W-1:0]             sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DATA_W-1:0]             sd_dq_in
);
  localparam int REF_CYC = CLK_MHZ * 15625 / 1000;
  localparam int PWR_CYC = CLK_MHZ * POWERUP_US;
  localparam int RD_HOLD = (CAS_LAT + T_RP > T_RC - T_RCD) ? CAS_LAT + T_RP : T_RC - T_RCD;
  localparam int WR_HOLD = (T_WR + T_RP > T_RC - T_RCD) ? T_WR + T_RP : T_RC - T_RCD;
  localparam int G_RP  = (T_RP    > 2) ? T_RP    - 2 : 0;
  localparam int G_RC  = (T_RC    > 2) ? T_RC    - 2 : 0;
  localparam int G_RCD = (T_RCD   > 2) ? T_RCD   - 2 : 0;
  localparam int G_MRD = (T_MRD   > 2) ? T_MRD   - 2 : 0;
  localparam int G_RD  = (RD_HOLD > 2) ? RD_HOLD - 2 : 0;
  localparam int G_WR  = (WR_HOLD > 2) ? WR_HOLD - 2 : 0;
  localparam int WC_W  = $clog2(PWR_CYC + RD_HOLD + WR_HOLD + T_RC + T_MRD + 4);
  localparam int RC_W  = $clog2(REF_CYC + 1);
  localparam logic [ROW_W-1:0] A_AP = ROW_W'(1) << 10;
  localparam logic [ROW_W-1:0] MODE = ROW_W'(CAS_LAT & 7) << 4;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_LMR = 4'b0000;

  typedef enum logic [2:0] {S_PWRUP, S_REF1, S_REF2, S_MRS, S_IDLE, S_RW, S_WAIT} st_t;

  st_t               state, nxt;
  logic [WC_W-1:0]   wcnt;
  logic [RC_W-1:0]   ref_cnt;
  logic              ref_pend;
  logic [3:0]        cmd;
  logic [CAS_LAT:0]  rd_sh;
  logic              r_wr;
  logic [COL_W-1:0]  r_col;
  logic [DATA_W-1:0] r_wdata;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign req_ready = (state == S_IDLE) && !ref_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_PWRUP;
      nxt       <= S_PWRUP;
      wcnt      <= WC_W'(PWR_CYC - 1);
      ref_cnt   <= RC_W'(REF_CYC - 1);
      ref_pend  <= 1'b0;
      cmd       <= C_NOP;
      rd_sh     <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      init_done <= 1'b0;
      sd_cke    <= 1'b0;
      sd_dqm    <= 1'b1;
      sd_ba     <= '0;
      sd_a      <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      r_wr      <= 1'b0;
      r_col     <= '0;
      r_wdata   <= '0;
    end else begin
      cmd      <= C_NOP;
      sd_dq_oe <= 1'b0;
      sd_cke   <= 1'b1;
      rd_sh    <= {rd_sh[CAS_LAT-1:0], 1'b0};
      rd_valid <= rd_sh[CAS_LAT];
      if (rd_sh[CAS_LAT]) rd_data <= sd_dq_in;

      if (ref_cnt == '0) begin
        ref_cnt <= RC_W'(REF_CYC - 1);
        if (init_done) ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt - 1'b1;
      end

      case (state)
        S_PWRUP: begin
          if (wcnt == '0) begin
            cmd   <= C_PRE;
            sd_a  <= A_AP;
            wcnt  <= WC_W'(G_RP);
            nxt   <= S_REF1;
            state <= S_WAIT;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        S_REF1: begin
          cmd   <= C_REF;
          wcnt  <= WC_W'(G_RC);
          nxt   <= S_REF2;
          state <= S_WAIT;
        end
        S_REF2: begin
          cmd   <= C_REF;
          wcnt  <= WC_W'(G_RC);
          nxt   <= S_MRS;
          state <= S_WAIT;
        end
        S_MRS: begin
          cmd   <= C_LMR;
          sd_ba <= '0;
          sd_a  <= MODE;
          wcnt  <= WC_W'(G_MRD);
          nxt   <= S_IDLE;
          state <= S_WAIT;
        end
        S_IDLE: begin
          if (ref_pend) begin
            cmd      <= C_REF;
            ref_pend <= 1'b0;
            wcnt     <= WC_W'(G_RC);
            nxt      <= S_IDLE;
            state    <= S_WAIT;
          end else if (req_valid) begin
            cmd     <= C_ACT;
            sd_ba   <= req_addr[COL_W+ROW_W +: BANK_W];
            sd_a    <= req_addr[COL_W +: ROW_W];
            r_wr    <= req_write;
            r_col   <= req_addr[COL_W-1:0];
            r_wdata <= req_wdata;
            wcnt    <= WC_W'(G_RCD);
            nxt     <= S_RW;
            state   <= S_WAIT;
          end
        end
        S_RW: begin
          sd_a  <= ROW_W'(r_col) | A_AP;
          nxt   <= S_IDLE;
          state <= S_WAIT;
          if (r_wr) begin
            cmd       <= C_WR;
            sd_dq_out <= r_wdata;
            sd_dq_oe  <= 1'b1;
            wcnt      <= WC_W'(G_WR);
          end else begin
            cmd      <= C_RD;
            rd_sh[0] <= 1'b1;
            wcnt     <= WC_W'(G_RD);
          end
        end
        S_WAIT: begin
          if (wcnt == '0) begin
            state <= nxt;
            if (nxt == S_IDLE) begin
              init_done <= 1'b1;
              sd_dqm    <= 1'b0;
            end
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        default: state <= S_PWRUP;
      endcase
    end
  end
endmodule

module sdram_seq_ctrl_chk #(
  parameter int CAS_LAT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sd_cs_n,
  input logic        sd_ras_n,
  input logic        sd_cas_n,
  input logic        sd_we_n,
  input logic [11:0] sd_a,
  input logic        sd_dq_oe,
  input logic        sd_cke,
  input logic        rd_valid,
  input logic        init_done,
  input logic        req_ready
);
  logic [3:0] c;
  assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c != 4'b0111) |=> (c == 4'b0111));
  p_autopre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0101 || c == 4'b0100) |-> sd_a[10]);
  p_oe_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (c == 4'b0100));
  p_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0000) |-> (sd_a == (12'(CAS_LAT & 7) << 4)) && !init_done);
  p_ready_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done && (c == 4'b0111));
  p_rdv_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_cke_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> sd_cke);
  p_ref_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0001) |-> !req_ready);
endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(.CAS_LAT(CAS_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a(sd_a), .sd_dq_oe(sd_dq_oe),
  .sd_cke(sd_cke), .rd_valid(rd_valid), .init_done(init_done), .req_ready(req_ready)
);

// File: tb/sdram_seq_ctrl_test.sv
module sdram_seq_ctrl_test;
  localparam int CLK_MHZ = 50, CL = 3, TRCD = 3, TRP = 3, TRC = 8, TWR = 2, TMRD = 2, PUS = 2;
  localparam int PWR = CLK_MHZ * PUS;
  localparam int REF = CLK_MHZ * 15625 / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rd_valid, init_done;
  logic [7:0] rd_data;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [11:0] sd_a;
  logic [7:0] sd_dq_out;
  logic [7:0] sd_dq_in = 8'hA5;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  sdram_seq_ctrl #(.CLK_MHZ(CLK_MHZ), .CAS_LAT(CL), .T_RCD(TRCD), .T_RP(TRP), .T_RC(TRC),
                   .T_WR(TWR), .T_MRD(TMRD), .POWERUP_US(PUS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .init_done(init_done),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] pat(logic [22:0] a);
    return 8'((a * 37) + (a >> 9) + 11);
  endfunction

  // memory model, sampled at falling edges
  logic [7:0] mem [logic [22:0]];
  int init_idx = 0, rd_cnt = 0, t_pre = -1000;
  int t_act = -1000, t_rd = -1000, t_wr = -1000, t_ref = -1000, t_lmr = -1000, t_read = 0;
  int last_ref = -1, ref_gap = 0, max_gap = 0, n_ref = 0;
  logic [7:0] rd_byte = 8'h00;
  logic [1:0] open_ba = '0;
  logic [11:0] open_row = '0;

  always @(negedge clk) if (rst_n) begin
    logic [3:0] c;
    logic [22:0] key;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rd_cnt > 0) begin
      rd_cnt = rd_cnt - 1;
      sd_dq_in = (rd_cnt == 0) ? rd_byte : 8'hA5;
    end else sd_dq_in = 8'hA5;
    if (sd_dq_oe && c != 4'b0100) check(0, "R8 oe outside write", int'(c), 4);
    case (c)
      4'b0111: ;
      4'b0010: begin
        check(init_idx == 0, "R2 precharge position", init_idx, 0);
        check(sd_a[10], "R2 precharge-all A10", int'(sd_a[10]), 1);
        check(cyc == PWR, "R1 power-up delay", cyc, PWR);
        t_pre = cyc; init_idx = 1;
      end
      4'b0001: begin
        if (init_idx < 4) begin
          check(init_idx == 1 || init_idx == 2, "R2 refresh position", init_idx, 1);
          check(cyc - ((init_idx == 1) ? t_pre : t_ref) >= ((init_idx == 1) ? TRP : TRC),
                "R6 init refresh spacing", cyc - t_ref, TRC);
          init_idx++;
        end else begin
          check(cyc - t_ref >= TRC, "R6 refresh-refresh", cyc - t_ref, TRC);
          check(cyc - t_act >= TRC, "R6 activate-refresh", cyc - t_act, TRC);
          check(cyc - t_rd >= CL + TRP, "R7 read-refresh", cyc - t_rd, CL + TRP);
          check(cyc - t_wr >= TWR + TRP, "R7 write-refresh", cyc - t_wr, TWR + TRP);
          if (last_ref >= 0) begin
            ref_gap = cyc - last_ref;
            if (ref_gap > max_gap) max_gap = ref_gap;
          end
          last_ref = cyc; n_ref++;
        end
        t_ref = cyc;
      end
      4'b0000: begin
        check(init_idx == 3, "R2 mode load position", init_idx, 3);
        check(sd_a == 12'(CL << 4), "R2 mode value", int'(sd_a), CL << 4);
        check(cyc - t_ref >= TRC, "R6 refresh-mode", cyc - t_ref, TRC);
        t_lmr = cyc; init_idx = 4;
      end
      4'b0011: begin
        check(init_idx == 4, "R2 activate before init", init_idx, 4);
        check(cyc - t_act >= TRC, "R6 activate-activate", cyc - t_act, TRC);
        check(cyc - t_ref >= TRC, "R6 refresh-activate", cyc - t_ref, TRC);
        check(cyc - t_lmr >= TMRD, "R6 mode-activate", cyc - t_lmr, TMRD);
        check(cyc - t_rd >= CL + TRP, "R7 read-activate", cyc - t_rd, CL + TRP);
        check(cyc - t_wr >= TWR + TRP, "R7 write-activate", cyc - t_wr, TWR + TRP);
        open_ba = sd_ba; open_row = sd_a; t_act = cyc;
      end
      4'b0101, 4'b0100: begin
        check(cyc - t_act >= TRCD, "R6 activate-column", cyc - t_act, TRCD);
        check(sd_a[10] && !sd_a[11] && !sd_a[9], "R5 column A10/A11/A9", int'(sd_a[11:9]), 2);
        check(sd_ba == open_ba, "R5 column bank", int'(sd_ba), int'(open_ba));
        key = {sd_ba, open_row, sd_a[8:0]};
        if (c == 4'b0100) begin
          check(sd_dq_oe, "R8 oe on write", int'(sd_dq_oe), 1);
          mem[key] = sd_dq_out; t_wr = cyc;
        end else begin
          rd_byte = mem.exists(key) ? mem[key] : 8'h00;
          rd_cnt = CL; t_rd = cyc; t_read = cyc;
        end
      end
      default: check(0, "R3 illegal command", int'(c), 7);
    endcase
  end

  task automatic issue(bit wr, logic [22:0] a, logic [7:0] d);
    int w = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready && w < 2000) begin @(negedge clk); w++; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(logic [22:0] a);
    int w = 0;
    issue(1'b0, a, 8'h00);
    while (!rd_valid && w < 100) begin @(negedge clk); w++; end
    check(rd_valid, "R9 rd_valid seen", int'(rd_valid), 1);
    check(cyc - t_read == CL + 1, "R9 read latency", cyc - t_read, CL + 1);
    check(rd_data == pat(a), "R4 R5 read data", int'(rd_data), int'(pat(a)));
    @(negedge clk);
    check(!rd_valid, "R9 single pulse", int'(rd_valid), 0);
  endtask

  task automatic finish_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", cyc, 0);
      finish_all();
    end
  end

  initial begin
    logic [11:0] rows [3];
    logic [8:0] cols [4];
    int w;
    rows[0] = 12'h000; rows[1] = 12'hA5C; rows[2] = 12'hFFF;
    cols[0] = 9'h000; cols[1] = 9'h001; cols[2] = 9'h155; cols[3] = 9'h1FF;
    repeat (5) @(negedge clk);
    check(!req_ready && !init_done, "R1 reset ready/init", int'({req_ready, init_done}), 0);
    check(!sd_cke && sd_dqm, "R1 reset cke/dqm", int'({sd_cke, sd_dqm}), 1);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 R3 reset NOP",
          int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    rst_n = 1'b1;
    w = 0;
    while (!init_done && w < 1000) begin @(negedge clk); w++; end
    check(init_done && init_idx == 4, "R2 init complete", init_idx, 4);
    check(!sd_dqm, "R2 dqm released", int'(sd_dqm), 0);
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 3; r++)
        for (int k = 0; k < 4; k++) begin
          logic [22:0] a;
          a = {2'(b), rows[r], cols[k]};
          issue(1'b1, a, pat(a));
        end
    for (int b = 3; b >= 0; b--)
      for (int r = 0; r < 3; r++)
        for (int k = 0; k < 4; k++)
          do_read({2'(b), rows[r], cols[k]});
    check(max_gap <= REF + 20, "R10 refresh under traffic", max_gap, REF + 20);
    check(n_ref >= 1, "R10 refresh occurred", n_ref, 1);
    repeat (3 * REF + 10) @(negedge clk);
    check(ref_gap == REF, "R10 idle refresh interval", ref_gap, REF);
    do_read({2'd2, 12'hA5C, 9'h155});
    done = 1'b1;
    finish_all();
  end
endmodule